// File: doc/BRIEF.md
# Sprite Attribute Fetch Sequencer

This block is the front stage of a scanline sprite engine. While a render window is open, it walks the object attribute table from the lowest entry to the highest. For each entry it reads the attribute words and decides whether the sprite is switched on and covers the target line. For rotate/scale (affine) sprites it also collects the four transform coefficients. Each qualifying entry is packed into a descriptor and offered to the pixel fetch stage over a valid/ready pair.

The attribute memory sees at most one read every two cycles, and a read never follows another on the next cycle. Read data returns on the cycle after the read. The pixel stage raises a stall input on the cycles it owns the memory. The sequencer issues reads only on the cycles where that input is low, so it can prefetch the next entry while the current sprite is still being drawn. A finished descriptor waits in an output register until it is accepted. Meanwhile the sequencer goes on to the next entry.

Top module: `obj_attr_seq`

## Requirements
- R1: No read is issued on the cycle right after a read. In a stretch with no stall, an open window and a descriptor accepted at once, consecutive reads are exactly two cycles apart.
- R2: Each window visits entries in ascending order starting at entry 0. The first read of entry i is a single 32-bit read of word 2i. That word holds attribute 0 in bits [15:0] and attribute 1 in bits [31:16].
- R3: Entry i yields a descriptor if and only if it qualifies. It is rejected when bit 8 = 0 and bit 9 = 1 (switched off). Otherwise it qualifies when (line − Y) mod 256 < H, where Y is bits [7:0], H = 8 << bits [15:14], and H is doubled when bits 8 and 9 are both 1. Descriptors carry the entry index and the word-2i value, and they appear in ascending index order.
- R4: For a qualifying entry the next read is word 2i+1, and the descriptor attribute 2 is its bits [15:0]. For a rejected entry the next read is word 2(i+1).
- R5: When bit 8 is set, attribute 2 is followed by four reads of words 2(4g+k)+1 for k = 0..3, where g is the low log2(N)−2 bits of word-2i bits [31:25]. Coefficient k comes from bits [31:16] of its word and sits at descriptor matrix bits [16k+15:16k]. A non-affine descriptor has an all-zero matrix.
- R6: No read is issued in a cycle where the stall input is high. The read sequence resumes unchanged afterwards.
- R7: Once the descriptor is valid, it and all its fields stay unchanged until the cycle in which it is accepted.
- R8: No read is issued while the window is closed. Reopening the window restarts the walk at entry 0.
- R9: After the last entry is handled, no further read occurs until the window reopens.
- R10: After reset, no read is issued and no descriptor is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_open | input | 1 | Render window open |
| line_tgt | input | 8 | Line being prepared |
| pix_stall | input | 1 | Pixel stage owns memory this cycle |
| mem_rd_en | output | 1 | Attribute memory read strobe |
| mem_rd_addr | output | log2(N)+1 | 32-bit word address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Pixel stage accepts descriptor |
| desc_idx | output | log2(N) | Entry index |
| desc_attr01 | output | 32 | Attribute 0/1 word |
| desc_attr2 | output | 16 | Attribute 2 |
| desc_affine | output | 1 | Affine sprite |
| desc_matrix | output | 64 | Four transform coefficients |

## Verification
The bench builds the block with NUM_ENTRIES = 16. At that size the coefficient group is two bits wide, and a full table walk takes a few hundred cycles. This brings several complete windows, the stop after the last entry, an early window close with restart, and a long back-pressure stretch within reach. Line values near zero exercise the modulo-256 wrap in the vertical test. The affine and double-area flags are mixed at random in every window.

// File: rtl/obj_attr_seq.sv
module obj_attr_seq #(
  parameter int NUM_ENTRIES = 128
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           win_open,
  input  logic [7:0]                     line_tgt,
  input  logic                           pix_stall,
  output logic                           mem_rd_en,
  output logic [$clog2(NUM_ENTRIES):0]   mem_rd_addr,
  input  logic [31:0]                    mem_rd_data,
  output logic                           desc_valid,
  input  logic                           desc_ready,
  output logic [$clog2(NUM_ENTRIES)-1:0] desc_idx,
  output logic [31:0]                    desc_attr01,
  output logic [15:0]                    desc_attr2,
  output logic                           desc_affine,
  output logic [63:0]                    desc_matrix
);
  localparam int IW = $clog2(NUM_ENTRIES);
  localparam int GW = IW - 2;
  localparam logic [IW-1:0] LAST = IW'(NUM_ENTRIES - 1);

  typedef enum logic [2:0] {ST_A01, ST_A2, ST_MAT, ST_HOLD, ST_DONE} st_t;

  st_t           state;
  logic          ph;
  logic [IW-1:0] idx;
  logic [1:0]    mcnt;
  logic [31:0]   w_attr01;
  logic [15:0]   w_attr2;
  logic [63:0]   w_mat;
  logic [15:0]   cur_attr2;
  logic [63:0]   cur_mat;

  wire       d_aff  = mem_rd_data[8];
  wire       d_flag = mem_rd_data[9];
  wire [7:0] d_dist = line_tgt - mem_rd_data[7:0];
  wire [8:0] d_h    = (9'd8 << mem_rd_data[15:14]) << (d_aff & d_flag);
  wire       d_vis  = !(!d_aff && d_flag) && ({1'b0, d_dist} < d_h);

  wire          w_aff = w_attr01[8];
  wire [GW-1:0] grp   = w_attr01[25 +: GW];

  wire fetching = (state == ST_A01) || (state == ST_A2) || (state == ST_MAT);
  wire out_free = !desc_valid || desc_ready;
  wire finish   = (state == ST_HOLD) ||
                  (ph && state == ST_A2 && !w_aff) ||
                  (ph && state == ST_MAT && mcnt == 2'd3);
  wire load     = win_open && finish && out_free;
  wire cull     = win_open && ph && state == ST_A01 && !d_vis;
  wire adv      = load || cull;

  assign mem_rd_en = win_open && !ph && fetching && !pix_stall;

  always_comb begin
    case (state)
      ST_A2:   mem_rd_addr = {idx, 1'b1};
      ST_MAT:  mem_rd_addr = {grp, mcnt, 1'b1};
      default: mem_rd_addr = {idx, 1'b0};
    endcase
  end

  always_comb begin
    cur_attr2 = (ph && state == ST_A2) ? mem_rd_data[15:0] : w_attr2;
    cur_mat   = w_mat;
    if (ph && state == ST_MAT) cur_mat[{mcnt, 4'b0} +: 16] = mem_rd_data[31:16];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_A01;
      ph          <= 1'b0;
      idx         <= '0;
      mcnt        <= '0;
      w_attr01    <= '0;
      w_attr2     <= '0;
      w_mat       <= '0;
      desc_valid  <= 1'b0;
      desc_idx    <= '0;
      desc_attr01 <= '0;
      desc_attr2  <= '0;
      desc_affine <= 1'b0;
      desc_matrix <= '0;
    end else begin
      if (load) begin
        desc_valid  <= 1'b1;
        desc_idx    <= idx;
        desc_attr01 <= w_attr01;
        desc_attr2  <= cur_attr2;
        desc_affine <= w_aff;
        desc_matrix <= w_aff ? cur_mat : '0;
      end else if (desc_ready) begin
        desc_valid <= 1'b0;
      end

      if (!win_open) begin
        state <= ST_A01;
        idx   <= '0;
        ph    <= 1'b0;
        mcnt  <= '0;
      end else begin
        ph <= ph ? 1'b0 : mem_rd_en;
        if (ph && state == ST_A01) w_attr01 <= mem_rd_data;
        if (ph && state == ST_A2)  w_attr2  <= mem_rd_data[15:0];
        if (ph && state == ST_MAT) begin
          w_mat <= cur_mat;
          mcnt  <= mcnt + 2'd1;
        end
        if (adv) begin
          if (idx == LAST) state <= ST_DONE;
          else begin
            idx   <= idx + 1'b1;
            state <= ST_A01;
          end
        end else if (ph && state == ST_A01) begin
          state <= ST_A2;
        end else if (ph && state == ST_A2 && w_aff) begin
          state <= ST_MAT;
          mcnt  <= '0;
        end else if (finish) begin
          state <= ST_HOLD;
        end
      end
    end
  end

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R1
  AST_REGULAR_NO_MATRIX: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_affine |-> desc_matrix == '0); // R5
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stall |-> !mem_rd_en); // R6
  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_idx) && $stable(desc_attr01)
      && $stable(desc_attr2) && $stable(desc_matrix) && $stable(desc_affine)); // R7
  AST_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> !mem_rd_en); // R8
endmodule

// File: tb/obj_attr_seq_tb.sv
`timescale 1ns/1ps
module obj_attr_seq_tb;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0, win_open = 1'b0, pix_stall = 1'b0, desc_ready = 1'b0;
  logic [7:0]    line_tgt = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [31:0]   mem_rd_data = '0;
  logic          desc_valid, desc_affine;
  logic [IW-1:0] desc_idx;
  logic [31:0]   desc_attr01;
  logic [15:0]   desc_attr2;
  logic [63:0]   desc_matrix;

  obj_attr_seq #(.NUM_ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .win_open(win_open), .line_tgt(line_tgt),
    .pix_stall(pix_stall), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_idx(desc_idx), .desc_attr01(desc_attr01), .desc_attr2(desc_attr2),
    .desc_affine(desc_affine), .desc_matrix(desc_matrix));

  logic [31:0] mem [0:2*N-1];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  int checks = 0, fails = 0, cyc = 0, last_rd = -100;
  bit clean = 0, first_rd = 0, hold_pend = 0;
  int rq_addr[$];
  string rq_tag[$];
  int dq[$];
  logic [127:0] saved;

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit qualifies(int i, int line);
    logic [31:0] a = mem[2*i];
    int h = 8 << a[15:14];
    if (a[8] && a[9]) h = h * 2;
    if (!a[8] && a[9]) return 1'b0;
    return ((line - int'(a[7:0])) & 255) < h;
  endfunction

  task automatic fill(int line);
    for (int i = 0; i < N; i++) begin
      logic [15:0] a0 = 16'($urandom);
      a0[13:10] = '0;
      a0[7:0] = 8'(line - int'($urandom % 48));
      if (i == 0) begin a0[7:0] = 8'(line + 100); a0[15:14] = 2'd0; a0[9:8] = 2'b00; end
      if (i == N-1) begin a0[7:0] = 8'(line); a0[9:8] = 2'b01; end
      mem[2*i]   = {16'($urandom), a0};
      mem[2*i+1] = $urandom;
    end
  endtask

  task automatic build(int line);
    rq_addr.delete(); rq_tag.delete(); dq.delete();
    for (int i = 0; i < N; i++) begin
      rq_addr.push_back(2*i); rq_tag.push_back("R2");
      if (qualifies(i, line)) begin
        rq_addr.push_back(2*i+1); rq_tag.push_back("R4");
        if (mem[2*i][8]) begin
          int g = int'(mem[2*i][26:25]);
          for (int k = 0; k < 4; k++) begin
            rq_addr.push_back(2*(4*g+k)+1); rq_tag.push_back("R5");
          end
        end
        dq.push_back(i);
      end
    end
    last_rd = -100; first_rd = 1;
  endtask

  task automatic step(bit w, int stall_pct, int ready_pct);
    @(negedge clk);
    win_open   = w;
    pix_stall  = int'($urandom % 100) < stall_pct;
    desc_ready = int'($urandom % 100) < ready_pct;
    #1;
    cyc++;
    if (hold_pend)
      check(desc_valid && {desc_idx, desc_attr01, desc_attr2, desc_matrix, desc_affine} == saved[IW+113-1:0],
            "R7", {desc_valid, desc_idx}, {1'b1, saved[IW+112:113]});
    hold_pend = desc_valid && !desc_ready;
    if (hold_pend) saved = 128'({desc_idx, desc_attr01, desc_attr2, desc_matrix, desc_affine});
    if (desc_valid && desc_ready) begin
      if (dq.size() == 0) check(0, "R3", desc_idx, 0);
      else begin
        int i = dq.pop_front();
        logic [63:0] m = '0;
        check(desc_idx == IW'(i), "R3", desc_idx, i);
        check(desc_attr01 == mem[2*i], "R3", desc_attr01, mem[2*i]);
        check(desc_attr2 == mem[2*i+1][15:0], "R4", desc_attr2, mem[2*i+1][15:0]);
        if (mem[2*i][8])
          for (int k = 0; k < 4; k++) m[16*k +: 16] = mem[2*(4*int'(mem[2*i][26:25])+k)+1][31:16];
        check(desc_affine == mem[2*i][8] && desc_matrix == m, "R5", desc_matrix, m);
      end
    end
    if (pix_stall || !desc_ready || !win_open) clean = 0;
    if (mem_rd_en) begin
      check(!pix_stall, "R6", pix_stall, 0);
      check(win_open, "R8", win_open, 1);
      check(cyc - last_rd != 1, "R1", cyc - last_rd, 2);
      if (clean && last_rd >= 0) check(cyc - last_rd == 2, "R1", cyc - last_rd, 2);
      if (first_rd) check(mem_rd_addr == 0, "R8", mem_rd_addr, 0);
      first_rd = 0;
      if (rq_addr.size() == 0) check(0, "R9", mem_rd_addr, 0);
      else begin
        int ea = rq_addr.pop_front();
        string t = rq_tag.pop_front();
        check(mem_rd_addr == AW'(ea), t, mem_rd_addr, ea);
      end
      last_rd = cyc;
      clean = 1;
    end
  endtask

  task automatic full_window(int line, int n, int stall_pct, int ready_pct);
    line_tgt = 8'(line);
    build(line);
    for (int c = 0; c < n; c++) step(1, stall_pct, ready_pct);
    for (int c = 0; c < 40; c++) step(1, 0, 100);
    check(rq_addr.size() == 0, "R9", rq_addr.size(), 0);
    check(dq.size() == 0, "R3", dq.size(), 0);
    for (int c = 0; c < 10; c++) step(0, 0, 100);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!mem_rd_en, "R10", mem_rd_en, 0);
    check(!desc_valid, "R10", desc_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int c = 0; c < 5; c++) step(0, 0, 100);
    check(!desc_valid, "R10", desc_valid, 0);

    fill(3);   full_window(3, 400, 0, 100);
    fill(100); full_window(100, 900, 40, 60);

    fill(60);
    line_tgt = 8'd60; build(60);
    for (int c = 0; c < 30; c++) step(1, 0, 100);
    step(0, 0, 100);
    rq_addr.delete(); rq_tag.delete(); dq.delete();
    for (int c = 0; c < 20; c++) step(0, 0, 100);
    full_window(60, 400, 0, 100);

    fill(200);
    line_tgt = 8'd200; build(200);
    for (int c = 0; c < 100; c++) step(1, 0, 0);
    for (int c = 0; c < 400; c++) step(1, 20, 100);
    check(rq_addr.size() == 0, "R9", rq_addr.size(), 0);
    check(dq.size() == 0, "R7", dq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule